// File: doc/BRIEF.md
# Reed-Solomon Parity Encoder with Virtual-Lane Distribution

This block is the transmit-side encoder for a Reed-Solomon code with 544 ten-bit symbols per codeword, 514 of which carry the message. The caller sends a stream of 10-bit symbols that is already framed: each 544-symbol frame starts with the 514 message symbols and ends with 30 placeholder slots, which are normally zero. The encoder passes the message through unchanged. It computes the 30 check symbols over GF(2^10) and puts them on the output in place of the placeholder slots.

Each output symbol also carries a virtual-lane tag. The lanes are filled round-robin, and the pointer returns to lane 0 at the start of every codeword. Three distribution modes are available: four lanes when both halves of a channel pair act as one encoder, two lanes for each independent half, and a single raw lane. The arithmetic is the same in all three modes. When the halves run independently, one instance is used per half. A mode request is sampled only on the first symbol of a codeword. Flow control uses valid/ready on both sides, and backpressure on the output passes straight through to the input.

Top module: `rsenc_lane_encoder`

## Requirements
- R1: The output symbols at codeword positions 0 to 513 equal the input symbols at the same positions, in the same order.
- R2: The output symbols at positions 514 to 543 are check symbols. The complete output codeword must evaluate to zero at alpha^0 through alpha^29, where alpha is the class of x over the field polynomial x^10+x^3+1. Bit i of a symbol is the coefficient of x^i, and position 0 is the highest-degree coefficient.
- R3: Input symbol values at positions 514 to 543 have no effect on any output symbol.
- R4: When the mode code sampled for a codeword is 0 (four lanes), o_lane equals the position modulo 4.
- R5: When the sampled mode code is 1 (two lanes), o_lane equals the position modulo 2.
- R6: When the sampled mode code is 2 or 3 (raw), o_lane is 0 for every symbol.
- R7: i_mode is sampled together with the first symbol (position 0) of a codeword. A change at any later position takes effect at the next codeword.
- R8: o_valid follows i_valid and i_ready follows o_ready. A symbol moves only in a cycle where both are high. A stalled cycle leaves the position, the lane and the check-symbol state unchanged, so no symbol is dropped or repeated.
- R9: An active-high synchronous reset returns the block to position 0 with cleared check-symbol state and lane 0, even in the middle of a codeword.
- R10: A message of all-zero symbols produces 30 all-zero check symbols.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| i_mode | input | 2 | Lane mode request: 0 four lanes, 1 two lanes, 2 or 3 raw |
| i_valid | input | 1 | Input symbol valid |
| i_ready | output | 1 | Encoder can accept the input symbol |
| i_sym | input | 10 | Input symbol (message or placeholder) |
| o_valid | output | 1 | Output symbol valid |
| o_ready | input | 1 | Downstream accepts the output symbol |
| o_sym | output | 10 | Encoded output symbol |
| o_lane | output | 2 | Virtual lane of the output symbol |

## Verification
Every result is due in the same cycle as the symbol that causes it. The output symbol and lane are combinational in the current input and the registered position, and the check-symbol registers and the lane pointer only move at the clock edge that ends an accepted beat. The bench therefore changes inputs just after the falling edge, reads o_sym and o_lane one time unit later, and records a symbol only when valid and ready are both high in that sample. Whole-codeword results (pass-through, syndromes, lane sequence) are evaluated once all 544 accepted symbols have been collected, so random stall patterns on either side cannot shift the expected values.

// File: rtl/rsenc_pkg.sv
package rsenc_pkg;

    parameter int SYM_W  = 10;
    parameter int N_SYM  = 544;
    parameter int K_SYM  = 514;
    localparam int N_PAR  = N_SYM - K_SYM;
    localparam int POS_W  = $clog2(N_SYM);
    localparam int LANE_W = 2;

    // low bits of the field polynomial x^10 + x^3 + 1
    localparam logic [SYM_W-1:0] FIELD_LO = SYM_W'(10'h009);

    typedef logic [SYM_W-1:0] sym_t;

    typedef enum logic [1:0] {
        MODE_QUAD = 2'd0,
        MODE_PAIR = 2'd1,
        MODE_RAW  = 2'd2
    } lane_mode_e;

    typedef struct packed {
        logic              parity_phase;
        logic [LANE_W-1:0] lane;
    } frame_state_t;

    function automatic sym_t gf_mul(input sym_t a, input sym_t b);
        sym_t acc;
        sym_t x;
        acc = '0;
        x   = a;
        for (int i = 0; i < SYM_W; i++) begin
            if (b[i]) acc = acc ^ x;
            x = {x[SYM_W-2:0], 1'b0} ^ (x[SYM_W-1] ? FIELD_LO : '0);
        end
        return acc;
    endfunction

    // low coefficients of prod_{i=0}^{N_PAR-1} (x + alpha^i); leading 1 implied
    function automatic logic [N_PAR*SYM_W-1:0] gen_coeffs();
        logic [(N_PAR+1)*SYM_W-1:0] g;
        sym_t root;
        g = '0;
        g[SYM_W-1:0] = sym_t'(1);
        root = sym_t'(1);
        for (int i = 0; i < N_PAR; i++) begin
            for (int j = N_PAR; j > 0; j--) begin
                g[j*SYM_W +: SYM_W] = g[(j-1)*SYM_W +: SYM_W]
                                    ^ gf_mul(g[j*SYM_W +: SYM_W], root);
            end
            g[0 +: SYM_W] = gf_mul(g[0 +: SYM_W], root);
            root = gf_mul(root, sym_t'(2));
        end
        return g[N_PAR*SYM_W-1:0];
    endfunction

    function automatic logic [LANE_W-1:0] lane_mask(input lane_mode_e m);
        case (m)
            MODE_QUAD: return LANE_W'(3);
            MODE_PAIR: return LANE_W'(1);
            default:   return '0;
        endcase
    endfunction

endpackage

// File: rtl/rsenc_frame_ctl.sv
module rsenc_frame_ctl
    import rsenc_pkg::*;
(
    input  logic         clk,
    input  logic         rst,
    input  logic         fire,
    input  logic [1:0]   req_mode,
    output frame_state_t st
);

    logic [POS_W-1:0]  pos_q;
    lane_mode_e        mode_q;
    logic [LANE_W-1:0] lane_q;
    lane_mode_e        eff_mode;
    logic              at_start;
    logic              at_last;

    always_comb begin
        at_start        = (pos_q == '0);
        at_last         = (pos_q == POS_W'(N_SYM - 1));
        eff_mode        = at_start ? lane_mode_e'(req_mode) : mode_q;
        st.parity_phase = (pos_q >= POS_W'(K_SYM));
        st.lane         = at_start ? '0 : lane_q;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pos_q  <= '0;
            mode_q <= MODE_QUAD;
            lane_q <= '0;
        end else if (fire) begin
            pos_q  <= at_last ? '0 : pos_q + POS_W'(1);
            mode_q <= eff_mode;
            lane_q <= at_last ? '0
                    : (LANE_W'(st.lane + LANE_W'(1)) & lane_mask(eff_mode));
        end
    end

endmodule

// File: rtl/rsenc_parity_lfsr.sv
module rsenc_parity_lfsr
    import rsenc_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic advance,
    input  logic parity_phase,
    input  sym_t din,
    output sym_t dout
);

    localparam logic [N_PAR*SYM_W-1:0] GEN = gen_coeffs();

    sym_t stage_q [N_PAR];
    sym_t prod    [N_PAR];
    sym_t fb;

    assign fb   = parity_phase ? '0 : (din ^ stage_q[N_PAR-1]);
    assign dout = stage_q[N_PAR-1];

    for (genvar i = 0; i < N_PAR; i++) begin : g_stage
        assign prod[i] = gf_mul(fb, GEN[i*SYM_W +: SYM_W]);
        if (i == 0) begin : g_first
            always_ff @(posedge clk) begin
                if (rst)          stage_q[0] <= '0;
                else if (advance) stage_q[0] <= prod[0];
            end
        end else begin : g_rest
            always_ff @(posedge clk) begin
                if (rst)          stage_q[i] <= '0;
                else if (advance) stage_q[i] <= stage_q[i-1] ^ prod[i];
            end
        end
    end

endmodule

// File: rtl/rsenc_lane_encoder.sv
module rsenc_lane_encoder
    import rsenc_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [1:0]        i_mode,
    input  logic              i_valid,
    output logic              i_ready,
    input  logic [SYM_W-1:0]  i_sym,
    output logic              o_valid,
    input  logic              o_ready,
    output logic [SYM_W-1:0]  o_sym,
    output logic [LANE_W-1:0] o_lane
);

    logic         fire;
    frame_state_t st;
    sym_t         par_sym;

    assign fire    = i_valid & o_ready;
    assign i_ready = o_ready;
    assign o_valid = i_valid;

    rsenc_frame_ctl u_ctl (
        .clk      (clk),
        .rst      (rst),
        .fire     (fire),
        .req_mode (i_mode),
        .st       (st)
    );

    rsenc_parity_lfsr u_lfsr (
        .clk          (clk),
        .rst          (rst),
        .advance      (fire),
        .parity_phase (st.parity_phase),
        .din          (i_sym),
        .dout         (par_sym)
    );

    assign o_sym  = st.parity_phase ? par_sym : i_sym;
    assign o_lane = st.lane;

endmodule

// File: rtl/rsenc_lane_encoder_chk.sv
module rsenc_lane_encoder_chk
    import rsenc_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic [1:0]        i_mode,
    input logic              i_valid,
    input logic              i_ready,
    input logic [SYM_W-1:0]  i_sym,
    input logic              o_valid,
    input logic              o_ready,
    input logic [SYM_W-1:0]  o_sym,
    input logic [LANE_W-1:0] o_lane
);

    logic             acc;
    logic [POS_W-1:0] pos;
    logic [1:0]       mode_q;
    logic [1:0]       eff;

    assign acc = o_valid && i_ready;
    assign eff = (pos == '0) ? i_mode : mode_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            pos    <= '0;
            mode_q <= 2'd0;
        end else if (acc) begin
            pos    <= (pos == POS_W'(N_SYM - 1)) ? '0 : pos + POS_W'(1);
            mode_q <= eff;
        end
    end

    // R1
    msg_passthru_chk: assert property (@(posedge clk) disable iff (rst)
        (i_valid && pos < POS_W'(K_SYM)) |-> (o_sym == i_sym));

    // R4
    quad_lane_chk: assert property (@(posedge clk) disable iff (rst)
        (o_valid && eff == 2'd0) |-> (o_lane == pos[1:0]));

    // R5
    pair_lane_chk: assert property (@(posedge clk) disable iff (rst)
        (o_valid && eff == 2'd1) |-> (o_lane == {1'b0, pos[0]}));

    // R6
    raw_lane_chk: assert property (@(posedge clk) disable iff (rst)
        (o_valid && eff[1]) |-> (o_lane == '0));

    // R8
    stall_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (o_valid && !o_ready) |=> $stable(o_lane));

    // R9
    reset_lane_chk: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (o_lane == '0));

endmodule

bind rsenc_lane_encoder rsenc_lane_encoder_chk u_chk (.*);

// File: tb/sim_rsenc_lane_encoder.sv
module sim_rsenc_lane_encoder;

    localparam int CLK_PERIOD = 10;
    localparam int NS = 544;
    localparam int KS = 514;
    localparam int NP = 30;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [1:0] i_mode = 2'd0;
    logic       i_valid = 1'b0;
    logic       i_ready;
    logic [9:0] i_sym = '0;
    logic       o_valid;
    logic       o_ready = 1'b0;
    logic [9:0] o_sym;
    logic [1:0] o_lane;

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 0;

    logic [9:0] msg  [NS];
    logic [9:0] cw   [NS];
    logic [1:0] lane [NS];
    int hs_err;

    always #(CLK_PERIOD/2) clk = ~clk;

    rsenc_lane_encoder u0 (.*);

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic logic [9:0] fmul(input logic [9:0] a, input logic [9:0] b);
        logic [19:0] p;
        p = '0;
        for (int i = 0; i < 10; i++) if (b[i]) p = p ^ (20'(a) << i);
        for (int i = 19; i >= 10; i--) if (p[i]) p = p ^ (20'h409 << (i - 10));
        return p[9:0];
    endfunction

    // number of nonzero syndromes of the captured codeword
    function automatic int bad_syndromes();
        logic [9:0] a;
        logic [9:0] s;
        int cnt;
        cnt = 0;
        a = 10'd1;
        for (int r = 0; r < NP; r++) begin
            s = '0;
            for (int k = 0; k < NS; k++) s = fmul(s, a) ^ cw[k];
            if (s != 0) cnt++;
            a = fmul(a, 10'd2);
        end
        return cnt;
    endfunction

    // stream one codeword; placeholders get junk if junk=1
    task automatic run_cw(input int mode, input bit zero_msg, input int stall,
                          input int chg_at, input int new_mode, input bit junk);
        int idx;
        idx = 0;
        hs_err = 0;
        for (int k = 0; k < KS; k++) msg[k] = zero_msg ? 10'd0 : 10'($urandom);
        while (idx < NS) begin
            @(negedge clk);
            i_valid = ($urandom % 100) >= 32'(stall);
            o_ready = ($urandom % 100) >= 32'(stall);
            i_sym   = (idx < KS) ? msg[idx] : (junk ? 10'($urandom) : 10'd0);
            i_mode  = 2'((idx >= chg_at) ? new_mode : mode);
            #1;
            if (o_valid != i_valid || i_ready != o_ready) hs_err++;
            if (i_valid && o_ready) begin
                cw[idx]   = o_sym;
                lane[idx] = o_lane;
                idx++;
            end
        end
        @(negedge clk);
        i_valid = 1'b0;
    endtask

    task automatic judge(input int mode, input string lreq, input string preq);
        int nl, pt_err, ln_err, syn;
        nl = (mode == 0) ? 4 : (mode == 1) ? 2 : 1;
        pt_err = 0;
        ln_err = 0;
        for (int k = 0; k < KS; k++) if (cw[k] != msg[k]) pt_err++;
        for (int k = 0; k < NS; k++) if (int'(lane[k]) != k % nl) ln_err++;
        syn = bad_syndromes();
        check(pt_err == 0, "R1 message passthrough", pt_err, 0);
        check(syn == 0, preq, syn, 0);
        check(ln_err == 0, lreq, ln_err, 0);
        check(hs_err == 0, "R8 handshake follow", hs_err, 0);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        i_valid = 1'b1;
        o_ready = 1'b0;
        i_sym = 10'h2a5;
        i_mode = 2'd1;
        #1;
        // R9 reset state: position 0, lane 0, pass-through of message
        check(o_lane == 2'd0, "R9 reset lane", o_lane, 0);
        check(o_sym == 10'h2a5, "R9 reset position 0", o_sym, 10'h2a5);
        i_valid = 1'b0;

        void'($urandom(32'd1234));

        run_cw(0, 0, 0, NS, 0, 0);   judge(0, "R4 quad lanes", "R2 parity");
        run_cw(1, 0, 30, NS, 1, 0);  judge(1, "R5 pair lanes", "R2 parity stall");
        run_cw(2, 0, 30, NS, 2, 0);  judge(2, "R6 raw lane", "R2 parity raw");
        run_cw(3, 0, 10, NS, 3, 0);  judge(3, "R6 raw lane code 3", "R2 parity code 3");
        run_cw(0, 0, 40, NS, 0, 1);  judge(0, "R4 quad lanes junk", "R3 placeholder ignored");

        run_cw(1, 1, 20, NS, 1, 0);
        begin
            int nz;
            nz = 0;
            for (int k = KS; k < NS; k++) if (cw[k] != 0) nz++;
            check(nz == 0, "R10 zero message parity", nz, 0);
        end

        // mode request changes mid-codeword: old mode holds until boundary
        run_cw(0, 0, 20, 5, 2, 0);   judge(0, "R7 mode held mid codeword", "R2 parity mode change");
        run_cw(2, 0, 20, NS, 2, 0);  judge(2, "R7 new mode at boundary", "R2 parity after change");

        // reset in the middle of a codeword
        run_cw(1, 0, 0, 100, 1, 0);
        @(negedge clk);
        i_valid = 1'b1; o_ready = 1'b1; i_sym = 10'h3ff;
        @(negedge clk);
        i_valid = 1'b0;
        @(negedge clk);
        rst = 1'b1;
        i_valid = 1'b1;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        i_valid = 1'b0;
        run_cw(0, 0, 25, NS, 0, 0);  judge(0, "R9 lanes after reset", "R9 parity after reset");

        finished = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 150000);
        if (!finished) begin
            n_chk++;
            n_bad++;
            $display("FAIL R8 watchdog expired actual=hung expected=done");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

endmodule